// File: doc/BRIEF.md
# Host Bus Write Capture with Direct FIFO Path

This block takes write cycles from an asynchronous 16-bit host bus and turns each one into a single event in the core clock domain. The bus has an active-low chip select, an active-low write strobe, a word address, a data word, a FIFO-select line and a byte-swap select line. Both strobes pass through two-flop synchronisers. A cycle is recognised when both strobes are low. It completes when either strobe returns high. On that completion the block samples address, data and the two select lines, and routes the word once.

The word can go to one of two places. The first is a transmit FIFO inside the block, which a consumer drains with a pop input through a show-ahead read port. The second is a one-cycle register-write strobe that carries the word address and the data. When the FIFO-select line is high, every write lands in the FIFO and the address does not matter, so a host that increments its address on each access can still stream data. When the select line is low, only the fixed FIFO port offset reaches the FIFO, and every other address becomes a register write.

Two sticky error flags share one clear input. One flag records a write dropped because the FIFO was full. The other records a cycle that began before the minimum idle gap had elapsed. Such a cycle is discarded.

Top module: `host_fifo_wr_capture`

## Requirements
- R1: A write cycle exists only while the synchronised chip select and the synchronised write strobe are both low. It ends when either one goes high, and the two may change in any order. A strobe that goes low while the other stays high starts nothing. Each accepted cycle produces exactly one event.
- R2: The event for a cycle (a FIFO push or a register strobe) becomes visible after the third rising clock edge that follows the first edge seeing either strobe high. Address, data and both select lines are sampled at that third edge.
- R3: With the FIFO-select input high at sampling, the word is pushed into the FIFO for any value of the 9-bit address, including its two lowest bits.
- R4: With FIFO-select low, the word is pushed only if the address equals the parameter FIFO_OFF (default 0x010). Any other address gives reg_wr_o high for exactly one cycle, with reg_off_o set to the address and reg_data_o set to the word. reg_off_o and reg_data_o hold their values otherwise.
- R5: With the swap input high at sampling, data bits [15:8] and [7:0] trade places before the word is routed. With the swap input low, the word is unchanged.
- R6: A push that arrives while the FIFO holds DEPTH (default 8) words is dropped and sets ovf_o. ovf_o stays high until flags_clr_i. A new overflow in the same cycle as the clear wins.
- R7: A cycle whose start comes fewer than MIN_GAP (default 3) sampled idle clocks after the previous cycle's end is discarded entirely and sets perr_o. perr_o is sticky and cleared by flags_clr_i, and a new error in the same cycle as the clear wins.
- R8: The FIFO returns words in push order. rd_data_o shows the oldest word while empty_o is low. pop_i removes it at the next edge. A pop while empty has no effect. full_o is high exactly when DEPTH words are held.
- R9: After reset the FIFO is empty and not full, ovf_o, perr_o and reg_wr_o are low, and the idle-gap rule is already satisfied for the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| addr_i | input | 9 | Host word address |
| data_i | input | 16 | Host write data |
| fifo_sel_i | input | 1 | Forces the write into the FIFO |
| swap_sel_i | input | 1 | Swaps the two data bytes |
| pop_i | input | 1 | Removes the oldest FIFO word |
| flags_clr_i | input | 1 | Clears ovf_o and perr_o |
| rd_data_o | output | 16 | Oldest FIFO word (show-ahead) |
| empty_o | output | 1 | FIFO holds no word |
| full_o | output | 1 | FIFO holds DEPTH words |
| ovf_o | output | 1 | Sticky: a push was dropped |
| perr_o | output | 1 | Sticky: a cycle started too early |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_off_o | output | 9 | Address of the register write |
| reg_data_o | output | 16 | Data of the register write |

## Verification
The FIFO contents, reg_wr_o and both error flags change after the third rising edge that follows a strobe release. The idle-gap decision depends on the number of edges at which both strobes had been seen idle before the new start. The flags follow the clear input after one edge, and a pop changes rd_data_o after one edge. The bench reference model records the strobe samples of past edges and makes every decision at the same edge the hardware would. It compares every output at each falling edge, after all register updates have settled. The latency, the dropped cycles and the strobe-order cases are therefore checked in the exact cycle where each result is due, not merely in the final FIFO contents.

// File: rtl/hfw_pkg.sv
package hfw_pkg;
    localparam int DW    = 16;
    localparam int BYTES = DW / 8;

    typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/hfw_strobe_sync.sv
module hfw_strobe_sync #(
    parameter int MIN_GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic wr_n_i,
    output logic fire_o,
    output logic bad_start_o
);
    localparam int GW = $clog2(MIN_GAP + 1) + 1;

    typedef struct packed {
        logic [1:0]    cs_sync;
        logic [1:0]    wr_sync;
        logic          act;
        logic          ok;
        logic [GW-1:0] gap;
    } st_t;

    st_t  st_d, st_q;
    logic act_s, start, fin, gap_ok;

    always_comb begin
        st_d   = st_q;
        act_s  = ~st_q.cs_sync[1] & ~st_q.wr_sync[1];
        start  = act_s & ~st_q.act;
        fin    = ~act_s & st_q.act;
        gap_ok = (st_q.gap >= GW'(MIN_GAP));

        st_d.cs_sync = {st_q.cs_sync[0], cs_n_i};
        st_d.wr_sync = {st_q.wr_sync[0], wr_n_i};
        st_d.act     = act_s;

        if (start) begin
            st_d.ok = gap_ok;
        end

        if (!act_s) begin
            if (fin) begin
                st_d.gap = GW'(1);
            end else if (!gap_ok) begin
                st_d.gap = st_q.gap + GW'(1);
            end
        end

        fire_o      = fin & st_q.ok;
        bad_start_o = start & ~gap_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_sync <= 2'b11;
            st_q.wr_sync <= 2'b11;
            st_q.act     <= 1'b0;
            st_q.ok      <= 1'b0;
            st_q.gap     <= GW'(MIN_GAP);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hfw_wr_decode.sv
module hfw_wr_decode
    import hfw_pkg::*;
#(
    parameter int             AW       = 9,
    parameter logic [AW-1:0]  FIFO_OFF = 'h010
) (
    input  logic          fire_i,
    input  logic          fifo_sel_i,
    input  logic          swap_sel_i,
    input  logic [AW-1:0] addr_i,
    input  word_t         data_i,
    output logic          push_o,
    output logic          reg_stb_o,
    output word_t         word_o
);
    word_t swapped;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign swapped[b*8 +: 8] = data_i[(BYTES-1-b)*8 +: 8];
    end

    always_comb begin
        word_o    = swap_sel_i ? swapped : data_i;
        push_o    = 1'b0;
        reg_stb_o = 1'b0;
        if (fire_i) begin
            if (fifo_sel_i || (addr_i == FIFO_OFF)) begin
                push_o = 1'b1;
            end else begin
                reg_stb_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hfw_txfifo.sv
module hfw_txfifo
    import hfw_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  word_t push_data_i,
    input  logic  pop_i,
    output word_t rd_data_o,
    output logic  empty_o,
    output logic  full_o,
    output logic  drop_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } st_t;

    st_t   st_d, st_q;
    word_t mem [DEPTH];
    logic  do_wr, do_rd;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        empty_o = (st_q.cnt == '0);
        full_o  = (st_q.cnt == CW'(DEPTH));
        do_wr   = push_i & ~full_o;
        do_rd   = pop_i & ~empty_o;
        drop_o  = push_i & full_o;
        if (do_wr) st_d.wptr = bump(st_q.wptr);
        if (do_rd) st_d.rptr = bump(st_q.rptr);
        if (do_wr && !do_rd)      st_d.cnt = st_q.cnt + CW'(1);
        else if (do_rd && !do_wr) st_d.cnt = st_q.cnt - CW'(1);
        rd_data_o = mem[st_q.rptr];
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wptr] <= push_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/host_fifo_wr_capture.sv
module host_fifo_wr_capture
    import hfw_pkg::*;
#(
    parameter int            AW       = 9,
    parameter int            DEPTH    = 8,
    parameter int            MIN_GAP  = 3,
    parameter logic [AW-1:0] FIFO_OFF = 'h010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          wr_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          fifo_sel_i,
    input  logic          swap_sel_i,
    input  logic          pop_i,
    input  logic          flags_clr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          ovf_o,
    output logic          perr_o,
    output logic          reg_wr_o,
    output logic [AW-1:0] reg_off_o,
    output logic [DW-1:0] reg_data_o
);
    typedef struct packed {
        logic          reg_wr;
        logic [AW-1:0] reg_off;
        word_t         reg_data;
        logic          ovf;
        logic          perr;
    } st_t;

    st_t   st_d, st_q;
    logic  fire, bad_start, push, reg_stb, drop;
    word_t word;

    hfw_strobe_sync #(.MIN_GAP(MIN_GAP)) sync_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n_i),
        .wr_n_i      (wr_n_i),
        .fire_o      (fire),
        .bad_start_o (bad_start)
    );

    hfw_wr_decode #(.AW(AW), .FIFO_OFF(FIFO_OFF)) dec_i (
        .fire_i     (fire),
        .fifo_sel_i (fifo_sel_i),
        .swap_sel_i (swap_sel_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .push_o     (push),
        .reg_stb_o  (reg_stb),
        .word_o     (word)
    );

    hfw_txfifo #(.DEPTH(DEPTH)) fifo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (word),
        .pop_i       (pop_i),
        .rd_data_o   (rd_data_o),
        .empty_o     (empty_o),
        .full_o      (full_o),
        .drop_o      (drop)
    );

    always_comb begin
        st_d        = st_q;
        st_d.reg_wr = reg_stb;
        if (reg_stb) begin
            st_d.reg_off  = addr_i;
            st_d.reg_data = word;
        end
        st_d.ovf  = drop | (st_q.ovf & ~flags_clr_i);
        st_d.perr = bad_start | (st_q.perr & ~flags_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_wr_o   = st_q.reg_wr;
    assign reg_off_o  = st_q.reg_off;
    assign reg_data_o = st_q.reg_data;
    assign ovf_o      = st_q.ovf;
    assign perr_o     = st_q.perr;
endmodule

// File: rtl/host_fifo_wr_capture_chk.sv
module host_fifo_wr_capture_chk #(
    parameter int            AW       = 9,
    parameter logic [AW-1:0] FIFO_OFF = 'h010
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flags_clr_i,
    input logic          reg_wr_o,
    input logic [AW-1:0] reg_off_o,
    input logic          ovf_o,
    input logic          perr_o,
    input logic          full_o,
    input logic          empty_o
);
    // R4
    reg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> reg_off_o != FIFO_OFF);

    // R1
    reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flags_clr_i) |=> ovf_o);

    // R6
    ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(full_o));

    // R7
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_o && !flags_clr_i) |=> perr_o);

    // R8
    full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));
endmodule

bind host_fifo_wr_capture host_fifo_wr_capture_chk #(.AW(AW), .FIFO_OFF(FIFO_OFF)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags_clr_i (flags_clr_i),
    .reg_wr_o    (reg_wr_o),
    .reg_off_o   (reg_off_o),
    .ovf_o       (ovf_o),
    .perr_o      (perr_o),
    .full_o      (full_o),
    .empty_o     (empty_o)
);

// File: tb/host_fifo_wr_capture_tb_top.sv
`timescale 1ns/1ps
module host_fifo_wr_capture_tb_top;
    localparam int            AW       = 9;
    localparam int            DEPTH    = 8;
    localparam int            MIN_GAP  = 3;
    localparam logic [AW-1:0] FIFO_OFF = 9'h010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   data = '0;
    logic          fsel = 1'b0, swap = 1'b0, pop = 1'b0, clr = 1'b0;
    logic [15:0]   rd_data, reg_data;
    logic          empty, full, ovf, perr, reg_wr;
    logic [AW-1:0] reg_off;

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R9";
    bit    done    = 1'b0;

    always #2 clk = ~clk;

    host_fifo_wr_capture #(.AW(AW), .DEPTH(DEPTH), .MIN_GAP(MIN_GAP), .FIFO_OFF(FIFO_OFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wr_n_i(wr_n), .addr_i(addr), .data_i(data),
        .fifo_sel_i(fsel), .swap_sel_i(swap), .pop_i(pop), .flags_clr_i(clr),
        .rd_data_o(rd_data), .empty_o(empty), .full_o(full), .ovf_o(ovf), .perr_o(perr),
        .reg_wr_o(reg_wr), .reg_off_o(reg_off), .reg_data_o(reg_data)
    );

    // Behavioural reference model
    logic [15:0]   m_q[$];
    bit            hist[$] = '{0, 0, 0, 0};
    int            low_run = MIN_GAP;
    bit            m_ok = 0, m_ovf = 0, m_perr = 0, m_reg_wr = 0;
    logic [AW-1:0] m_off = '0;
    logic [15:0]   m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            hist = '{0, 0, 0, 0};
            low_run = MIN_GAP;
            m_ok = 0; m_ovf = 0; m_perr = 0; m_reg_wr = 0;
            m_off = '0; m_rdata = '0;
        end else begin
            bit act_s, prev, st, fin, fire, bad, drop, was_full, pushit;
            logic [15:0] w;
            hist.push_back(!cs_n && !wr_n);
            if (hist.size() > 8) void'(hist.pop_front());
            act_s = hist[hist.size()-3];
            prev  = hist[hist.size()-4];
            st    = act_s && !prev;
            fin   = !act_s && prev;
            bad   = 0;
            if (st) begin
                m_ok = (low_run >= MIN_GAP);
                bad  = !m_ok;
            end
            if (act_s) low_run = 0;
            else if (low_run < 1000) low_run++;
            fire = fin && m_ok;
            w = swap ? {data[7:0], data[15:8]} : data;
            was_full = (m_q.size() == DEPTH);
            pushit = fire && (fsel || addr == FIFO_OFF);
            drop = pushit && was_full;
            if (pop && m_q.size() > 0) void'(m_q.pop_front());
            if (pushit && !was_full) m_q.push_back(w);
            m_reg_wr = fire && !pushit;
            if (m_reg_wr) begin m_off = addr; m_rdata = w; end
            m_ovf  = drop || (m_ovf && !clr);
            m_perr = bad || (m_perr && !clr);
        end
    end

    task automatic chk(input string name, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, name, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("empty_o", 32'(empty), 32'(m_q.size() == 0));
            chk("full_o",  32'(full),  32'(m_q.size() == DEPTH));
            chk("ovf_o",   32'(ovf),   32'(m_ovf));
            chk("perr_o",  32'(perr),  32'(m_perr));
            chk("reg_wr_o", 32'(reg_wr), 32'(m_reg_wr));
            if (m_q.size() > 0) chk("rd_data_o", 32'(rd_data), 32'(m_q[0]));
            if (m_reg_wr) begin
                chk("reg_off_o",  32'(reg_off),  32'(m_off));
                chk("reg_data_o", 32'(reg_data), 32'(m_rdata));
            end
        end
    end

    // order 0: both strobes together; 1: cs first, cs released first; 2: wr released first
    task automatic hwr(input logic [AW-1:0] a, input logic [15:0] d, input logic fs,
                       input logic sw, input int order, input int gap);
        @(negedge clk);
        addr = a; data = d; fsel = fs; swap = sw;
        if (order == 1) begin
            cs_n = 1'b0; @(negedge clk); wr_n = 1'b0;
        end else begin
            cs_n = 1'b0; wr_n = 1'b0;
        end
        repeat (3) @(negedge clk);
        if (order == 1) begin
            cs_n = 1'b1; @(negedge clk); wr_n = 1'b1;
        end else if (order == 2) begin
            wr_n = 1'b1; @(negedge clk); cs_n = 1'b1;
        end else begin
            cs_n = 1'b1; wr_n = 1'b1;
        end
        repeat (4 + gap) @(negedge clk);
    endtask

    task automatic pops(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pop = 1'b1;
            @(negedge clk); pop = 1'b0;
        end
    endtask

    task automatic clear_flags();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected done");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        cur_req = "R9";                 // reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        cur_req = "R3";                 // direct path ignores the address
        hwr(9'h000, 16'h1111, 1'b1, 1'b0, 0, 0);
        hwr(9'h1FF, 16'h2222, 1'b1, 1'b0, 0, 0);
        hwr(9'h0AB, 16'h3333, 1'b1, 1'b0, 0, 0);
        hwr(9'h102, 16'h4444, 1'b1, 1'b0, 0, 0);

        cur_req = "R4";                 // normal path decode
        hwr(FIFO_OFF, 16'h5555, 1'b0, 1'b0, 0, 0);
        hwr(9'h004, 16'hA0A1, 1'b0, 1'b0, 0, 0);
        hwr(9'h011, 16'hB0B1, 1'b0, 1'b0, 0, 2);

        cur_req = "R5";                 // byte swap
        hwr(9'h020, 16'h12EF, 1'b1, 1'b1, 0, 0);
        hwr(9'h030, 16'hC3D4, 1'b0, 1'b1, 0, 0);

        cur_req = "R1";                 // strobe orderings
        hwr(9'h001, 16'h6677, 1'b1, 1'b0, 1, 0);
        hwr(9'h002, 16'h8899, 1'b1, 1'b0, 2, 0);
        @(negedge clk); cs_n = 1'b0;    // select alone: no cycle
        repeat (5) @(negedge clk); cs_n = 1'b1;
        repeat (5) @(negedge clk); wr_n = 1'b0;   // strobe alone: no cycle
        repeat (5) @(negedge clk); wr_n = 1'b1;
        repeat (6) @(negedge clk);

        cur_req = "R8";                 // order and pop on empty
        pops(DEPTH + 3);

        cur_req = "R2";                 // single write latency
        hwr(9'h055, 16'hDEAD, 1'b1, 1'b0, 0, 0);
        pops(1);

        cur_req = "R6";                 // overflow
        for (int i = 0; i < DEPTH + 2; i++) hwr(9'(i), 16'(16'h7000 + i), 1'b1, 1'b0, 0, 0);
        repeat (3) @(negedge clk);
        clear_flags();
        pops(DEPTH);

        cur_req = "R7";                 // idle gap too short
        @(negedge clk); addr = 9'h000; data = 16'hAAAA; fsel = 1'b1; swap = 1'b0;
        cs_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1;
        @(negedge clk); data = 16'hBBBB; wr_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
        repeat (8) @(negedge clk);
        hwr(9'h000, 16'hCCCC, 1'b1, 1'b0, 0, 0);
        clear_flags();
        pops(3);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule